// File: doc/BRIEF.md
# Half-Duplex Encoder Serial Link Controller

This block runs one command/response exchange at a time with an absolute position encoder over a shared half-duplex differential serial pair. It owns the direction pin of the line transceiver. On a host command strobe it turns the transceiver to transmit and sends a one-character command. It waits until that character's stop bit has fully left the wire, turns the line around to receive, and collects a fixed number of reply characters. A complete, error-free reply is copied into a parallel latch. The host reads the latch one byte at a time through a 3-bit address and a single strobe.

Bit timing comes from the block's own divider. On the nominal 20 MHz reference, a bit period of 8 reference clocks gives 2.5 Mb/s. A half-rate enable paces the transaction steps. Each character has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high. The receiver confirms a start edge at mid-bit and samples every later bit at its centre. A bad stop bit or a silent encoder ends the exchange with a status flag, and the latch keeps its previous contents.

Top module: `enc_link_ctrl`

## Requirements
- R1: During and after reset, `line_dir_o` is 1 (receive), `line_tx_o` is 1, `host_rdata_o` is 0, and the status byte and all reply bytes read as 0.
- R2: A strobe with address 0..3 while idle sends the command code `CMD_CODES[addr]` as one character. The character is a low start bit, 8 data bits LSB first and a high stop bit, and each bit lasts `CLKS_PER_BIT` clocks.
- R3: `line_dir_o` is 0 before the start bit appears and stays 0 for the whole character. `line_tx_o` is never low while `line_dir_o` is 1.
- R4: `line_dir_o` returns to 1 only after the full stop bit has been on the line, and it does so within a few clocks of that point.
- R5: After turnaround the block receives `RESP_BYTES` characters. On completion the first character reads at address 4, the second at 5 and the third at 6. The status byte (address 7) then reads 0x08: bit 3 reply valid, bit 0 busy clear.
- R6: A low pulse on `line_rx_i` that is high again at the mid-point of a would-be start bit is rejected, and the reply that follows is received correctly.
- R7: A received stop bit that is low ends the exchange with status 0x02 (bit 1, framing error), and the reply bytes keep their previous values.
- R8: If no character starts within `TIMEOUT_CLKS` clocks of turnaround, the exchange ends with status 0x04 (bit 2, timeout) after that many clocks, and the reply bytes are unchanged.
- R9: A command strobe while a transaction is pending or running is ignored: no second character is sent.
- R10: Activity on `line_rx_i` while no transaction is in its receive phase changes neither the reply bytes nor the status.
- R11: `host_rdata_o` changes only on a strobe with address 4..7. It loads the selected byte on that clock edge and holds it through command strobes and whole transactions.
- R12: Starting a new command clears the framing-error, timeout and reply-valid flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_stb_i | input | 1 | Host strobe: issue a command (addr 0..3) or load a read byte (addr 4..7) |
| host_addr_i | input | 3 | Command select or read select |
| host_rdata_o | output | 8 | Registered read data |
| line_rx_i | input | 1 | Receive data from the transceiver |
| line_tx_o | output | 1 | Transmit data to the transceiver, idle high |
| line_dir_o | output | 1 | Transceiver direction: 0 transmit, 1 receive |

## Verification
The hardest situations to reach from the ports are the failures in the middle of a reply. Examples are a stop bit that goes bad only on the second character after a clean first one, and a short low spike just after turnaround that must not be mistaken for a start bit. The bench plays the encoder itself. It waits until it sees the direction pin rise, then drives the reply at bit level. In one exchange it holds a single stop bit low. In another it injects a two-clock spike before a normal reply. It also sweeps every command address against several reply gaps, measures the silent-encoder timeout against the cycle counter, and confirms that the latch and the read register survive each abort.

// File: rtl/enc_link_pkg.sv
package enc_link_pkg;
  localparam int unsigned CHAR_W     = 8;
  localparam int unsigned FRAME_BITS = CHAR_W + 2;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LEAD, SEQ_TX, SEQ_RX} seq_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  typedef struct packed {
    logic reply_ok;
    logic timeout;
    logic frame_err;
    logic busy;
  } link_status_t;
endpackage

// File: rtl/enc_link_clkdiv.sv
module enc_link_clkdiv #(
  parameter int unsigned CLKS_PER_BIT = 8,
  parameter int unsigned CE_DIV       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ce_ctl_o,
  output logic bit_tick_o
);
  localparam int unsigned BW = $clog2(CLKS_PER_BIT);
  localparam logic [BW-1:0] BIT_LAST = BW'(CLKS_PER_BIT - 1);

  logic [BW-1:0] bit_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      bit_tick_o <= 1'b0;
    end else begin
      bit_tick_o <= (bit_cnt_q == BIT_LAST);
      bit_cnt_q  <= (bit_cnt_q == BIT_LAST) ? '0 : bit_cnt_q + BW'(1);
    end
  end

  generate
    if (CE_DIV <= 1) begin : g_ce_full
      assign ce_ctl_o = 1'b1;
    end else begin : g_ce_div
      localparam int unsigned CW = $clog2(CE_DIV);
      localparam logic [CW-1:0] CE_LAST = CW'(CE_DIV - 1);
      logic [CW-1:0] ce_cnt_q;
      logic          ce_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ce_cnt_q <= '0;
          ce_q     <= 1'b0;
        end else begin
          ce_q     <= (ce_cnt_q == CE_LAST);
          ce_cnt_q <= (ce_cnt_q == CE_LAST) ? '0 : ce_cnt_q + CW'(1);
        end
      end
      assign ce_ctl_o = ce_q;
    end
  endgenerate
endmodule

// File: rtl/enc_link_tx.sv
module enc_link_tx
  import enc_link_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              go_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              line_o,
  output logic              busy_o
);
  localparam int unsigned IW = $clog2(FRAME_BITS + 1);
  localparam logic [IW-1:0] IDX_DONE = IW'(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg_q;
  logic [IW-1:0]         idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      idx_q   <= '0;
      line_o  <= 1'b1;
      busy_o  <= 1'b0;
    end else if (!busy_o) begin
      if (go_i) begin
        shreg_q <= {1'b1, data_i, 1'b0};
        idx_q   <= '0;
        busy_o  <= 1'b1;
      end
    end else if (bit_tick_i) begin
      // One extra tick after the stop bit starts: busy drops only once it has lasted a full bit
      if (idx_q == IDX_DONE) begin
        busy_o <= 1'b0;
      end else begin
        line_o  <= shreg_q[0];
        shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
        idx_q   <= idx_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/enc_link_rx.sv
module enc_link_rx
  import enc_link_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              line_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              byte_o,
  output logic              ferr_o,
  output logic              active_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam int unsigned BW = $clog2(CHAR_W);
  localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(CHAR_W - 1);

  rx_state_e   state_q;
  logic [1:0]  sync_q;
  logic        rx_s;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bidx_q;
  logic [CHAR_W-1:0] shreg_q;

  assign rx_s     = sync_q[1];
  assign data_o   = shreg_q;
  assign active_o = (state_q != RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      byte_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      byte_o <= 1'b0;
      ferr_o <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          RX_IDLE: if (!rx_s) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
          RX_START: begin
            if (cnt_q == HALF_LAST) begin
              cnt_q   <= '0;
              bidx_q  <= '0;
              state_q <= rx_s ? RX_IDLE : RX_DATA;   // high at mid-bit: glitch
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          RX_DATA: begin
            if (cnt_q == FULL_LAST) begin
              cnt_q   <= '0;
              shreg_q <= {rx_s, shreg_q[CHAR_W-1:1]};
              if (bidx_q == BIT_LAST) state_q <= RX_STOP;
              else                    bidx_q  <= bidx_q + BW'(1);
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          RX_STOP: begin
            if (cnt_q == FULL_LAST) begin
              cnt_q   <= '0;
              byte_o  <= rx_s;
              ferr_o  <= !rx_s;
              state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/enc_link_seq.sv
module enc_link_seq
  import enc_link_pkg::*;
#(
  parameter int unsigned RESP_BYTES   = 3,
  parameter int unsigned TIMEOUT_CLKS = 512,
  parameter logic [3:0][CHAR_W-1:0] CMD_CODES = {8'hA4, 8'h3C, 8'h91, 8'h1A}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              host_stb_i,
  input  logic [2:0]        host_addr_i,
  output logic [7:0]        host_rdata_o,
  output logic              tx_go_o,
  output logic [CHAR_W-1:0] tx_data_o,
  input  logic              tx_busy_i,
  output logic              rx_en_o,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_byte_i,
  input  logic              rx_ferr_i,
  input  logic              rx_active_i,
  output logic              dir_o,
  output logic              frame_err_o,
  output logic              timeout_o
);
  localparam int unsigned IW = (RESP_BYTES > 1) ? $clog2(RESP_BYTES) : 1;
  localparam int unsigned TW = $clog2(TIMEOUT_CLKS);
  localparam logic [IW-1:0] IDX_LAST = IW'(RESP_BYTES - 1);
  localparam logic [TW-1:0] T_LAST   = TW'(TIMEOUT_CLKS - 1);

  seq_state_e state_q;
  logic pend_q, commit_q, ok_q;
  logic [CHAR_W-1:0] code_q;
  logic [IW-1:0] idx_q;
  logic [TW-1:0] timer_q;
  logic [RESP_BYTES-1:0][CHAR_W-1:0] rbuf_q, latch_q;
  link_status_t status;
  logic [3:0][7:0] view;
  logic cmd_stb, rd_stb;

  assign cmd_stb   = host_stb_i && !host_addr_i[2];
  assign rd_stb    = host_stb_i &&  host_addr_i[2];
  assign tx_data_o = code_q;
  assign rx_en_o   = (state_q == SEQ_RX);

  assign status.busy      = pend_q || commit_q || (state_q != SEQ_IDLE);
  assign status.frame_err = frame_err_o;
  assign status.timeout   = timeout_o;
  assign status.reply_ok  = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      pend_q      <= 1'b0;
      commit_q    <= 1'b0;
      ok_q        <= 1'b0;
      code_q      <= '0;
      idx_q       <= '0;
      timer_q     <= '0;
      rbuf_q      <= '0;
      tx_go_o     <= 1'b0;
      dir_o       <= 1'b1;
      frame_err_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      tx_go_o  <= 1'b0;
      commit_q <= 1'b0;
      if (commit_q) ok_q <= 1'b1;
      if (cmd_stb && state_q == SEQ_IDLE && !pend_q && !commit_q) begin
        pend_q <= 1'b1;
        code_q <= CMD_CODES[host_addr_i[1:0]];
      end
      unique case (state_q)
        SEQ_IDLE: if (ce_i && pend_q) begin
          pend_q      <= 1'b0;
          dir_o       <= 1'b0;
          frame_err_o <= 1'b0;
          timeout_o   <= 1'b0;
          ok_q        <= 1'b0;
          state_q     <= SEQ_LEAD;
        end
        SEQ_LEAD: if (ce_i) begin
          tx_go_o <= 1'b1;
          state_q <= SEQ_TX;
        end
        SEQ_TX: if (ce_i && !tx_busy_i) begin
          dir_o   <= 1'b1;
          idx_q   <= '0;
          timer_q <= '0;
          state_q <= SEQ_RX;
        end
        SEQ_RX: begin
          if (rx_ferr_i) begin
            frame_err_o <= 1'b1;
            state_q     <= SEQ_IDLE;
          end else if (rx_byte_i) begin
            rbuf_q[idx_q] <= rx_data_i;
            timer_q       <= '0;
            if (idx_q == IDX_LAST) begin
              commit_q <= 1'b1;
              state_q  <= SEQ_IDLE;
            end else begin
              idx_q <= idx_q + IW'(1);
            end
          end else if (rx_active_i) begin
            timer_q <= '0;
          end else if (timer_q == T_LAST) begin
            timeout_o <= 1'b1;
            state_q   <= SEQ_IDLE;
          end else begin
            timer_q <= timer_q + TW'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       latch_q <= '0;
    else if (commit_q) latch_q <= rbuf_q;
  end

  generate
    for (genvar g = 0; g < 3; g++) begin : g_view
      if (g < RESP_BYTES) begin : g_byte
        assign view[g] = latch_q[g];
      end else begin : g_pad
        assign view[g] = '0;
      end
    end
  endgenerate
  assign view[3] = {4'h0, status};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     host_rdata_o <= '0;
    else if (rd_stb) host_rdata_o <= view[host_addr_i[1:0]];
  end
endmodule

// File: rtl/enc_link_ctrl.sv
module enc_link_ctrl
  import enc_link_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 8,
  parameter int unsigned CE_DIV       = 2,
  parameter int unsigned RESP_BYTES   = 3,
  parameter int unsigned TIMEOUT_CLKS = 512,
  parameter logic [3:0][CHAR_W-1:0] CMD_CODES = {8'hA4, 8'h3C, 8'h91, 8'h1A}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_stb_i,
  input  logic [2:0] host_addr_i,
  output logic [7:0] host_rdata_o,
  input  logic       line_rx_i,
  output logic       line_tx_o,
  output logic       line_dir_o
);
  logic ce_ctl, bit_tick;
  logic tx_go, tx_busy;
  logic [CHAR_W-1:0] tx_data, rx_data;
  logic rx_en, rx_byte, rx_ferr, rx_active;
  logic frame_err, timeout;

  enc_link_clkdiv #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .CE_DIV      (CE_DIV)
  ) u_clkdiv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ctl_o  (ce_ctl),
    .bit_tick_o(bit_tick)
  );

  enc_link_tx u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_tick_i(bit_tick),
    .go_i      (tx_go),
    .data_i    (tx_data),
    .line_o    (line_tx_o),
    .busy_o    (tx_busy)
  );

  enc_link_rx #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en),
    .line_i  (line_rx_i),
    .data_o  (rx_data),
    .byte_o  (rx_byte),
    .ferr_o  (rx_ferr),
    .active_o(rx_active)
  );

  enc_link_seq #(
    .RESP_BYTES  (RESP_BYTES),
    .TIMEOUT_CLKS(TIMEOUT_CLKS),
    .CMD_CODES   (CMD_CODES)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (ce_ctl),
    .host_stb_i  (host_stb_i),
    .host_addr_i (host_addr_i),
    .host_rdata_o(host_rdata_o),
    .tx_go_o     (tx_go),
    .tx_data_o   (tx_data),
    .tx_busy_i   (tx_busy),
    .rx_en_o     (rx_en),
    .rx_data_i   (rx_data),
    .rx_byte_i   (rx_byte),
    .rx_ferr_i   (rx_ferr),
    .rx_active_i (rx_active),
    .dir_o       (line_dir_o),
    .frame_err_o (frame_err),
    .timeout_o   (timeout)
  );
endmodule

// File: rtl/enc_link_ctrl_chk.sv
module enc_link_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_tx_i,
  input logic       line_dir_i,
  input logic       host_stb_i,
  input logic [7:0] host_rdata_i,
  input logic       rx_en_i,
  input logic       tx_busy_i,
  input logic       ferr_i,
  input logic       tout_i
);
  p_tx_needs_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tx_i |-> !line_dir_i);

  p_turn_after_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_dir_i) |-> (line_tx_i && !tx_busy_i));

  p_rx_only_listening_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i |-> line_dir_i);

  p_abort_flags_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ferr_i && tout_i));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_stb_i |=> $stable(host_rdata_i));
endmodule

bind enc_link_ctrl enc_link_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_tx_i   (line_tx_o),
  .line_dir_i  (line_dir_o),
  .host_stb_i  (host_stb_i),
  .host_rdata_i(host_rdata_o),
  .rx_en_i     (rx_en),
  .tx_busy_i   (tx_busy),
  .ferr_i      (frame_err),
  .tout_i      (timeout)
);

// File: tb/enc_link_ctrl_bench.sv
module enc_link_ctrl_bench;
  localparam int CPB = 8;
  localparam int TMO = 512;
  localparam logic [3:0][7:0] CMDS = {8'h5E, 8'h02, 8'hC7, 8'h39};
  localparam int M_OK = 0, M_SILENT = 1, M_FERR = 2, M_GLITCH = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic stb;
  logic [2:0] addr;
  logic [7:0] rdata;
  logic rx_line, tx_line, dir;
  int n_vec = 0, n_bad = 0;
  longint cyc = 0;
  logic [7:0] exp_r [3];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  enc_link_ctrl #(
    .CLKS_PER_BIT(CPB), .CE_DIV(2), .RESP_BYTES(3), .TIMEOUT_CLKS(TMO), .CMD_CODES(CMDS)
  ) u_enc_link_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .host_stb_i(stb), .host_addr_i(addr),
    .host_rdata_o(rdata), .line_rx_i(rx_line), .line_tx_o(tx_line), .line_dir_o(dir)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); stb = 1'b1; addr = a;
    @(negedge clk); stb = 1'b0;
    v = rdata;
  endtask

  task automatic host_cmd(input logic [1:0] a);
    @(negedge clk); stb = 1'b1; addr = {1'b0, a};
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d, input bit stop_ok);
    logic [9:0] fr;
    fr = {stop_ok, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_line = fr[i];
      repeat (CPB) @(negedge clk);
    end
    rx_line = 1'b1;
  endtask

  task automatic tx_expect(input logic [7:0] code, output longint t_rise);
    int w;
    logic [7:0] d;
    logic dir_bad;
    w = 0;
    while (tx_line !== 1'b0 && w < 400) begin @(negedge clk); w++; end
    chk({7'b0, w < 400}, 8'd1, "R2 start bit appears");
    chk({7'b0, dir}, 8'd0, "R3 direction low at start edge");
    repeat (4) @(posedge clk); @(negedge clk);
    chk({7'b0, tx_line}, 8'd0, "R2 start bit at mid-bit");
    dir_bad = dir;
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(posedge clk); @(negedge clk);
      d[i] = tx_line; dir_bad |= dir;
    end
    chk(d, code, "R2 command data bits");
    repeat (CPB) @(posedge clk); @(negedge clk);
    chk({7'b0, tx_line}, 8'd1, "R2 stop bit high");
    dir_bad |= dir;
    chk({7'b0, dir_bad}, 8'd0, "R3 direction low through character");
    repeat (3) @(posedge clk); @(negedge clk);
    chk({7'b0, dir}, 8'd0, "R4 direction held to end of stop bit");
    w = 0;
    while (dir !== 1'b1 && w < 40) begin @(negedge clk); w++; end
    chk({7'b0, w < 40}, 8'd1, "R4 direction returns to receive");
    t_rise = cyc;
  endtask

  task automatic do_txn(input logic [1:0] a, input int gap, input int mode,
                        input logic [7:0] r0, r1, r2, input bit extra, output longint t_rise);
    host_cmd(a);
    if (extra) host_cmd(a + 2'd1);
    tx_expect(CMDS[a], t_rise);
    if (extra) host_cmd(a + 2'd2);
    case (mode)
      M_OK: begin
        repeat (gap) @(negedge clk);
        send_char(r0, 1'b1); send_char(r1, 1'b1); send_char(r2, 1'b1);
      end
      M_FERR: begin
        send_char(r0, 1'b1); send_char(r1, 1'b0);
      end
      M_GLITCH: begin
        rx_line = 1'b0; repeat (2) @(negedge clk);
        rx_line = 1'b1; repeat (12) @(negedge clk);
        send_char(r0, 1'b1); send_char(r1, 1'b1); send_char(r2, 1'b1);
      end
      default: ;
    endcase
  endtask

  task automatic wait_idle(output logic [7:0] st);
    int n;
    n = 0;
    host_read(3'd7, st);
    while (st[0] && n < 2000) begin host_read(3'd7, st); n++; end
  endtask

  task automatic chk_reply(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 3; i++) begin
      host_read(3'(4 + i), v);
      chk(v, exp_r[i], tag);
    end
  endtask

  function automatic logic [7:0] rbyte(input int a, input int g, input int i);
    return 8'(a * 71 + g * 13 + i * 107 + 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, st, held;
    longint tr;
    int lows;
    rst_n = 1'b0; stb = 1'b0; addr = '0; rx_line = 1'b1;
    for (int i = 0; i < 3; i++) exp_r[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk({7'b0, dir}, 8'd1, "R1 direction in reset");
    chk({7'b0, tx_line}, 8'd1, "R1 tx line in reset");
    chk(rdata, 8'h00, "R1 read data in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    host_read(3'd7, v); chk(v, 8'h00, "R1 status after reset");
    chk_reply("R1 reply bytes after reset");

    // R2..R5 sweep: every command against several reply gaps
    for (int a = 0; a < 4; a++) begin
      for (int gi = 0; gi < 3; gi++) begin
        do_txn(2'(a), gi * 13, M_OK, rbyte(a, gi, 0), rbyte(a, gi, 1), rbyte(a, gi, 2), 1'b0, tr);
        for (int i = 0; i < 3; i++) exp_r[i] = rbyte(a, gi, i);
        wait_idle(st);
        chk(st, 8'h08, "R5 status after reply");
        chk_reply("R5 reply byte");
      end
    end

    // R6 spike before reply
    do_txn(2'd1, 0, M_GLITCH, 8'hFF, 8'h00, 8'hA5, 1'b0, tr);
    exp_r[0] = 8'hFF; exp_r[1] = 8'h00; exp_r[2] = 8'hA5;
    wait_idle(st);
    chk(st, 8'h08, "R6 status after spike");
    chk_reply("R6 reply after spike");

    // R7 bad stop bit on second char
    do_txn(2'd2, 0, M_FERR, 8'h11, 8'h22, 8'h33, 1'b0, tr);
    wait_idle(st);
    chk(st, 8'h02, "R7 framing error status");
    chk_reply("R7 latch kept after framing error");

    // R12 flags cleared by next command
    do_txn(2'd0, 4, M_OK, 8'h3A, 8'hC4, 8'h7E, 1'b0, tr);
    exp_r[0] = 8'h3A; exp_r[1] = 8'hC4; exp_r[2] = 8'h7E;
    wait_idle(st);
    chk(st, 8'h08, "R12 status after framing error cleared");
    chk_reply("R12 reply after recovery");

    // R8 silent encoder
    do_txn(2'd3, 0, M_SILENT, 8'h00, 8'h00, 8'h00, 1'b0, tr);
    wait_idle(st);
    chk(st, 8'h04, "R8 timeout status");
    chk({7'b0, (cyc - tr) >= TMO && (cyc - tr) <= TMO + 8}, 8'd1, "R8 timeout window");
    chk_reply("R8 latch kept after timeout");

    do_txn(2'd2, 7, M_OK, 8'h81, 8'h42, 8'h24, 1'b0, tr);
    exp_r[0] = 8'h81; exp_r[1] = 8'h42; exp_r[2] = 8'h24;
    wait_idle(st);
    chk(st, 8'h08, "R12 status after timeout cleared");

    // R9 strobes while busy
    do_txn(2'd1, 3, M_OK, 8'h5C, 8'hE3, 8'h09, 1'b1, tr);
    exp_r[0] = 8'h5C; exp_r[1] = 8'hE3; exp_r[2] = 8'h09;
    wait_idle(st);
    chk(st, 8'h08, "R9 status with ignored strobes");
    chk_reply("R9 reply with ignored strobes");
    lows = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (!tx_line) lows++; end
    chk(8'(lows), 8'd0, "R9 no second character sent");

    // R10 line activity outside receive phase
    send_char(8'h00, 1'b1);
    send_char(8'h6D, 1'b0);
    repeat (20) @(negedge clk);
    host_read(3'd7, st);
    chk(st, 8'h08, "R10 status unchanged by idle line");
    chk_reply("R10 latch unchanged by idle line");

    // R11 read data hold
    host_read(3'd5, held);
    chk(held, exp_r[1], "R11 read loads selected byte");
    host_cmd(2'd3);
    tx_expect(CMDS[3], tr);
    send_char(8'h99, 1'b1); send_char(8'h66, 1'b1); send_char(8'hF0, 1'b1);
    repeat (80) @(negedge clk);
    chk(rdata, held, "R11 read data held through transaction");
    exp_r[0] = 8'h99; exp_r[1] = 8'h66; exp_r[2] = 8'hF0;
    chk_reply("R11 new reply after hold");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule